// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives a slower timing signal from its input clock. It divides the clock by a 16-bit integer N that sits in a 32-bit control word. The word is written through a simple write port and can always be read back. Its upper half holds N. Its two lowest bits are a pair of enable flags. The divider runs only when both flags are 1 and N is 2 or more.

While it runs, the block gives two outputs. The first is a one-cycle enable pulse once every N input cycles. The second is a clock output that toggles with a 50% duty cycle; it is produced only when N is even. Software normally changes the rate in two steps. It first writes the new divisor with both flags cleared, which stops the divider. It then writes the same divisor again with both flags set. If the divisor changes while the divider is running, the new value is taken up only at the end of the current period, so no short period is produced.

Top module: `clk_rate_divider`

## Requirements
- R1: Reset leaves the control word at zero and holds both `tickOut` and `divClkOut` low.
- R2: A write stores `wrData` into the control word at the clock edge where `wrEn` is high. From the next cycle `rdData` returns that word unchanged, and it stays unchanged while `wrEn` is low.
- R3: While running with divisor N (word bits 31:16), `tickOut` pulses once every N input cycles. The gap from one pulse to the next is exactly N cycles, for N from 2 up to 65535.
- R4: Suppose a write makes the divider run from the stopped state. The first `tickOut` pulse is then high in the cycle that follows the Nth rising edge after the write edge.
- R5: If word bits 1:0 hold any value other than 2'b11, `tickOut` and `divClkOut` stay low.
- R6: With bits 1:0 equal to 2'b11 but a divisor of 0 or 1, both outputs stay low.
- R7: Writing an all-zero word stops the divider. Both outputs are low from the second cycle after the write edge.
- R8: A write of a divisor with bits 1:0 cleared leaves the divider stopped. A later write of the same divisor with bits 1:0 set starts it, and R4 timing applies.
- R9: A divisor written while the divider runs does not shorten or stretch the period in progress. The new N applies from the next period on.
- R10: For an even N, `divClkOut` is high for N/2 cycles and low for N/2 cycles in every period, and it is low while `tickOut` is high. For an odd N it stays low.
- R11: `tickOut` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word: divisor in 31:16, enable flags in 1:0 |
| rdData | output | 32 | Current control word |
| tickOut | output | 1 | One-cycle pulse every N cycles |
| divClkOut | output | 1 | 50% duty divided clock (even N only) |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the middle of a running period (R9). It is only visible as the length of one particular gap between pulses. The stimulus waits for a pulse, writes the new divisor a fixed number of cycles later, and then checks two gaps: the rest of the current period against the old divisor, and the following period against the new one. Constrained-random rounds mix random small divisors with random flag pairs. They cover the enabled case and each of the three disabled flag combinations. Directed cases cover divisors 0, 1, 2, 3 and 1000.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int WORD_W  = 32;
  localparam int DIV_W   = 16;
  localparam int DIV_LSB = 16;
  localparam int EN_W    = 2;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] nextDiv;
  } divCmd_t;
endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
  import clk_div_pkg::*;
#(
  parameter int MIN_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] ctlWord,
  output divCmd_t           cmd
);
  localparam logic [EN_W-1:0]  ALL_ON = {EN_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] divField;
  logic [EN_W-1:0]  enField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctlWord <= '0;
    else if (wrEn) ctlWord <= wrData;
  end

  assign divField    = ctlWord[DIV_LSB +: DIV_W];
  assign enField     = ctlWord[EN_W-1:0];
  assign cmd.nextDiv = divField;
  assign cmd.run     = (enField == ALL_ON) && (divField >= DIV_FLOOR);
endmodule

// File: rtl/clk_div_datapath.sv
module clk_div_datapath
  import clk_div_pkg::*;
#(
  parameter bit EVEN_CLK_EN = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCmd_t cmd,
  output logic    tickOut,
  output logic    divClkOut
);
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] count;
  logic             runningQ;
  logic             atEnd;

  // A fresh start uses the word's divisor; a running divider keeps its own until terminal count.
  assign curDiv = runningQ ? activeDiv : cmd.nextDiv;
  assign atEnd  = (count == curDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDiv <= '0;
      count     <= '0;
      runningQ  <= 1'b0;
      tickOut   <= 1'b0;
    end else if (!cmd.run) begin
      count     <= '0;
      runningQ  <= 1'b0;
      tickOut   <= 1'b0;
    end else begin
      runningQ <= 1'b1;
      if (atEnd) begin
        count     <= '0;
        tickOut   <= 1'b1;
        activeDiv <= cmd.nextDiv;
      end else begin
        count     <= count + DIV_W'(1);
        tickOut   <= 1'b0;
        activeDiv <= curDiv;
      end
    end
  end

  generate
    if (EVEN_CLK_EN) begin : gEvenClk
      logic             clkQ;
      logic [DIV_W-1:0] halfMark;
      assign halfMark = (curDiv >> 1) - DIV_W'(1);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               clkQ <= 1'b0;
        else if (!cmd.run || atEnd)              clkQ <= 1'b0;
        else if (!curDiv[0] && count == halfMark) clkQ <= 1'b1;
      end
      assign divClkOut = clkQ;
    end else begin : gNoClk
      assign divClkOut = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/clk_rate_divider.sv
module clk_rate_divider
  import clk_div_pkg::*;
#(
  parameter int MIN_DIV     = 2,
  parameter bit EVEN_CLK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              tickOut,
  output logic              divClkOut
);
  divCmd_t cmd;

  clk_div_ctrl #(.MIN_DIV(MIN_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctlWord(rdData), .cmd(cmd)
  );

  clk_div_datapath #(.EVEN_CLK_EN(EVEN_CLK_EN)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tickOut(tickOut), .divClkOut(divClkOut)
  );
endmodule

// File: rtl/clk_rate_divider_chk.sv
module clk_rate_divider_chk
  import clk_div_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [WORD_W-1:0] wrData,
  input logic [WORD_W-1:0] rdData,
  input logic              tickOut,
  input logic              divClkOut
);
  logic runNow;
  assign runNow = (rdData[EN_W-1:0] == {EN_W{1'b1}}) && (rdData[DIV_LSB +: DIV_W] >= DIV_W'(2));

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R1: assert (rdData == '0 && !tickOut && !divClkOut);
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));

  assert_hold_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  assert_stopped_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |=> !tickOut);

  assert_low_at_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> !divClkOut);

  assert_single_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> !tickOut);
endmodule

bind clk_rate_divider clk_rate_divider_chk uChk (.*);

// File: tb/tb_clk_rate_divider.sv
module tb_clk_rate_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickOut, divClkOut;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  clk_rate_divider dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
                        .rdData(rdData), .tickOut(tickOut), .divClkOut(divClkOut));

  function automatic bit expRuns(input logic [31:0] w);
    return (w[1:0] == 2'b11) && (w[31:16] >= 16'd2);
  endfunction
  function automatic int expHigh(input int n);
    return (n % 2 == 0) ? n / 2 : 0;
  endfunction
  function automatic logic [31:0] mkWord(input int n, input logic [1:0] en);
    return {n[15:0], 14'd0, en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); wrEn = 1'b1; wrData = w;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // samples until a tick is seen; returns sample count and divClk-high samples
  task automatic waitTick(input int limit, output int k, output int high);
    k = 0; high = 0;
    do begin
      @(negedge clk); k++;
      if (divClkOut) high++;
    end while (!tickOut && k < limit);
  endtask

  task automatic checkSilent(input int cycles, input string req);
    int seen = 0;
    @(negedge clk);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tickOut || divClkOut) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic runCase(input int n, input string req);
    int k, high;
    wr(32'd0); repeat (2) @(negedge clk);
    wr(mkWord(n, 2'b11));
    waitTick(n + 5, k, high);
    check(k == n, {req, " first tick (R4)"}, k, n);
    waitTick(n + 5, k, high);
    check(k == n, {req, " period (R3)"}, k, n);
    check(high == expHigh(n), {req, " duty (R10)"}, high, expHigh(n));
  endtask

  task automatic mainSeq();
    int k, high;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdData == 32'd0, "R1 word", rdData, 0);
    check(!tickOut && !divClkOut, "R1 outputs", {tickOut, divClkOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 readback
    wr(32'hA5A5_5A58);
    check(rdData == 32'hA5A5_5A58, "R2 readback", rdData, 32'hA5A5_5A58);
    repeat (3) @(negedge clk);
    check(rdData == 32'hA5A5_5A58, "R2 hold", rdData, 32'hA5A5_5A58);
    // directed divisors
    runCase(2, "R3 n2");
    runCase(3, "R3 n3");
    runCase(1000, "R3 n1000");
    // R6 divisor below two
    wr(32'd0); wr(mkWord(1, 2'b11)); checkSilent(20, "R6 div1");
    wr(mkWord(0, 2'b11)); checkSilent(20, "R6 div0");
    // R5 flag combinations
    wr(mkWord(4, 2'b01)); checkSilent(20, "R5 en01");
    wr(mkWord(4, 2'b10)); checkSilent(20, "R5 en10");
    // R7 zero stops a running divider
    runCase(6, "R7 pre");
    wr(32'd0); checkSilent(30, "R7 stop");
    // R8 two-step rate change
    wr(mkWord(10, 2'b00));
    check(rdData == mkWord(10, 2'b00), "R8 word", rdData, mkWord(10, 2'b00));
    checkSilent(30, "R8 stopped");
    wr(mkWord(10, 2'b11));
    waitTick(15, k, high);
    check(k == 10, "R8 start", k, 10);
    // R9 change while running: tick seen, write lands 2 edges later
    wr(32'd0); repeat (2) @(negedge clk);
    wr(mkWord(4, 2'b11));
    waitTick(10, k, high);
    wr(mkWord(7, 2'b11));
    waitTick(10, k, high);
    check(k == 2, "R9 old period remainder", k, 2);
    waitTick(12, k, high);
    check(k == 7, "R9 new period", k, 7);
    check(high == 0, "R10 odd low", high, 0);
    // constrained random rounds
    for (int r = 0; r < 14; r++) begin
      int n = 2 + int'($urandom % 30);
      logic [1:0] en = 2'($urandom % 4);
      logic [31:0] w = mkWord(n, en);
      wr(32'd0); repeat (2) @(negedge clk);
      wr(w);
      if (expRuns(w)) begin
        waitTick(n + 5, k, high);
        check(k == n, "R4 random first", k, n);
        waitTick(n + 5, k, high);
        check(k == n, "R3 random period", k, n);
        check(high == expHigh(n), "R10 random duty", high, expHigh(n));
      end else begin
        checkSilent(2 * n + 4, "R5 random disabled");
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule